// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels. It turns each channel's expiry strobe into an interrupt and keeps one status bit per channel. The channel configuration selects the delivery. A channel can hold a line high until software acknowledges it (level), raise a line for a single cycle (edge), or issue a message-write request instead of driving a pin. In the message case, the address and data come from that channel's 64-bit message register.

Each channel picks one of the interrupt lines with a route field. A legacy override pins channel 0 to line 0 and channel 1 to line 8, whatever their route fields say. While the override is active, the external real-time-clock interrupt that normally passes to line 8 is blocked. When the override ends, the line follows the live clock input again.

Software clears status by writing ones to the acknowledge port. When several channels drive the same line, their contributions are ORed.

Top module: `tmr_irq_router`

## Requirements
- R1: Outside legacy mode, a channel asserts the line whose index is its 5-bit route field (`ch_route[5*i +: 5]`).
- R2: In legacy mode, channel 0 uses line 0 and channel 1 uses line 8, regardless of their route fields. Other channels keep their route field.
- R3: A level-mode event (`ch_level`=1) on an enabled channel sets its `sts_q` bit one cycle later. The routed line stays high until the bit is cleared.
- R4: An edge-mode event clears the channel's `sts_q` bit and raises its routed line for exactly the one cycle after the event.
- R5: An event that arrives while `ch_en` for that channel is 0, or `glob_en` is 0, clears the status bit and drives no line.
- R6: A cycle with `sts_wr`=1 clears every `sts_q` bit whose `sts_wdata` bit is 1 and leaves the other bits as they were. If the same channel has a level event in that cycle, the event wins and the bit ends up set.
- R7: An enabled event with `ch_msg_en`=1 drives no line and leaves the status bit unchanged. One cycle later it pulses `msg_req` for a single cycle, with `msg_addr` = bits 63:32 and `msg_data` = bits 31:0 of that channel's message register. If several channels do this in the same cycle, the lowest-numbered one is sent and the others are dropped.
- R8: In the cycle after `ch_msg_en` of a channel rises, that channel's status bit is 0 and its line is released.
- R9: Line 8 follows `rtc_irq` combinationally when legacy mode is off. It ignores `rtc_irq` when legacy mode is on. After legacy mode is left, line 8 shows the current `rtc_irq` level.
- R10: A line is high when any channel routed to it is holding or pulsing it, or when the clock passthrough drives it.
- R11: While `rst_n` is low, all status bits are 0, `msg_req` is 0 and no channel drives a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glob_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy routing override |
| rtc_irq | input | 1 | External real-time-clock interrupt level |
| ch_event | input | NCH | Per-channel expiry strobe, one cycle |
| ch_en | input | NCH | Per-channel interrupt enable |
| ch_level | input | NCH | 1 = level mode, 0 = edge mode |
| ch_msg_en | input | NCH | Per-channel message delivery enable |
| ch_route | input | NCH*5 | Per-channel line index |
| ch_msg_cfg | input | NCH*64 | Per-channel message address (63:32) and data (31:0) |
| sts_wr | input | 1 | Status acknowledge write strobe |
| sts_wdata | input | NCH | Ones mark channels to acknowledge |
| sts_q | output | NCH | Per-channel status |
| irq_out | output | NLINES | Interrupt lines |
| msg_req | output | 1 | Message write request, one cycle |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
An acknowledge write and a new event on the same channel can fall into the same cycle. A message-enable rising edge can also coincide with an event. The bench provokes the first case by holding a level status, then writing a one to its acknowledge bit in the same cycle as a fresh level event on that channel. It expects the bit to remain set and the line to stay high. The rising-edge case comes up in the sweep: message enable rises one cycle before the event, and the bench checks both the release and the request that follows.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int NCH       = 4,
  parameter int NLINES    = 32,
  parameter int RTC_LINE  = 8,
  parameter int LEG0_LINE = 0,
  parameter int LEG1_LINE = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glob_en,
  input  logic                  legacy_en,
  input  logic                  rtc_irq,
  input  logic [NCH-1:0]        ch_event,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH-1:0]        ch_level,
  input  logic [NCH-1:0]        ch_msg_en,
  input  logic [NCH*5-1:0]      ch_route,
  input  logic [NCH*64-1:0]     ch_msg_cfg,
  input  logic                  sts_wr,
  input  logic [NCH-1:0]        sts_wdata,
  output logic [NCH-1:0]        sts_q,
  output logic [NLINES-1:0]     irq_out,
  output logic                  msg_req,
  output logic [31:0]           msg_addr,
  output logic [31:0]           msg_data
);
  localparam int RW = 5;

  logic [NCH-1:0] pulse_q, msg_en_q, sts_n, pulse_n;
  logic           req_n;
  logic [31:0]    addr_n, data_n;
  logic [RW-1:0]  route_eff [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_route
    if (i == 0) begin : g_l0
      assign route_eff[i] = legacy_en ? RW'(LEG0_LINE) : ch_route[i*RW +: RW];
    end else if (i == 1) begin : g_l1
      assign route_eff[i] = legacy_en ? RW'(LEG1_LINE) : ch_route[i*RW +: RW];
    end else begin : g_plain
      assign route_eff[i] = ch_route[i*RW +: RW];
    end
  end

  always_comb begin
    sts_n   = sts_q;
    pulse_n = '0;
    req_n   = 1'b0;
    addr_n  = msg_addr;
    data_n  = msg_data;
    for (int i = 0; i < NCH; i++) begin
      if (sts_wr && sts_wdata[i]) sts_n[i] = 1'b0;
      if (ch_msg_en[i] && !msg_en_q[i]) sts_n[i] = 1'b0;
      if (ch_event[i]) begin
        if (!glob_en || !ch_en[i]) begin
          sts_n[i] = 1'b0;
        end else if (ch_msg_en[i]) begin
          if (!req_n) begin
            req_n  = 1'b1;
            addr_n = ch_msg_cfg[i*64+32 +: 32];
            data_n = ch_msg_cfg[i*64 +: 32];
          end
        end else if (ch_level[i]) begin
          sts_n[i] = 1'b1;
        end else begin
          sts_n[i]   = 1'b0;
          pulse_n[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q    <= '0;
      pulse_q  <= '0;
      msg_en_q <= '0;
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      sts_q    <= sts_n;
      pulse_q  <= pulse_n;
      msg_en_q <= ch_msg_en;
      msg_req  <= req_n;
      msg_addr <= addr_n;
      msg_data <= data_n;
    end
  end

  always_comb begin
    irq_out = '0;
    for (int i = 0; i < NCH; i++)
      if (sts_q[i] || pulse_q[i]) irq_out[route_eff[i]] = 1'b1;
    if (rtc_irq && !legacy_en) irq_out[RTC_LINE] = 1'b1;
  end
endmodule

module tmr_irq_router_chk #(
  parameter int NCH      = 4,
  parameter int NLINES   = 32,
  parameter int RTC_LINE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en,
  input logic              legacy_en,
  input logic [NCH-1:0]    ch_event,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_level,
  input logic [NCH-1:0]    ch_msg_en,
  input logic              sts_wr,
  input logic [NCH-1:0]    sts_wdata,
  input logic [NCH-1:0]    sts_q,
  input logic [NLINES-1:0] irq_out,
  input logic              msg_req
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_event[i] && ch_en[i] && glob_en && !ch_msg_en[i] && ch_level[i]) |=> sts_q[i]);
    assert_edge_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_event[i] && ch_en[i] && glob_en && !ch_msg_en[i] && !ch_level[i]) |=> !sts_q[i]);
    assert_disabled_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_event[i] && (!ch_en[i] || !glob_en)) |=> !sts_q[i]);
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[i] && !ch_event[i]) |=> !sts_q[i]);
    assert_msg_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_msg_en[i]) |=> !sts_q[i]);
  end

  assert_msg_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(glob_en && |(ch_event & ch_en & ch_msg_en)));
  assert_msg_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !$past(glob_en && |(ch_event & ch_en & ch_msg_en))) |-> 1'b0);
  assert_rtc_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en && sts_q == '0 && !$past(|ch_event)) |-> !irq_out[RTC_LINE]);
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NCH(NCH), .NLINES(NLINES), .RTC_LINE(RTC_LINE)) u_chk (.*);

// File: tb/tmr_irq_router_tb.sv
`timescale 1ns/1ps
module tmr_irq_router_tb;
  localparam int NCH = 4;
  localparam int NL  = 32;

  logic clk = 0, rst_n = 0, glob_en = 0, legacy_en = 0, rtc_irq = 0, sts_wr = 0;
  logic [NCH-1:0] ch_event = '0, ch_en = '0, ch_level = '0, ch_msg_en = '0, sts_wdata = '0;
  logic [NCH*5-1:0] ch_route = '0;
  logic [NCH*64-1:0] ch_msg_cfg = '0;
  logic [NCH-1:0] sts_q;
  logic [NL-1:0] irq_out;
  logic msg_req;
  logic [31:0] msg_addr, msg_data;

  int vectors = 0, fails = 0;
  logic [NCH-1:0] m_sts = '0, m_pulse = '0, m_msgq = '0;
  logic m_req = 0;
  logic [31:0] m_addr = '0, m_data = '0;

  always #2 clk = ~clk;

  tmr_irq_router u_dut (.*);

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] e = '0;
    for (int i = 0; i < NCH; i++) begin
      if (m_sts[i] || m_pulse[i]) begin
        int r;
        if (legacy_en && i == 0) r = 0;
        else if (legacy_en && i == 1) r = 8;
        else r = int'(ch_route[i*5 +: 5]);
        e[r] = 1'b1;
      end
    end
    if (rtc_irq && !legacy_en) e[8] = 1'b1;
    return e;
  endfunction

  task automatic compare(input string tag);
    logic [NL-1:0] el = exp_lines();
    vectors++;
    if (irq_out !== el || sts_q !== m_sts || msg_req !== m_req ||
        (m_req && (msg_addr !== m_addr || msg_data !== m_data))) begin
      fails++;
      $display("FAIL %s: lines=%h sts=%b req=%b addr=%h data=%h expected lines=%h sts=%b req=%b addr=%h data=%h",
               tag, irq_out, sts_q, msg_req, msg_addr, msg_data, el, m_sts, m_req, m_addr, m_data);
    end
  endtask

  task automatic tick(input string tag);
    logic [NCH-1:0] s = m_sts, p = '0;
    logic rq = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sts_wr && sts_wdata[i]) s[i] = 1'b0;
      if (ch_msg_en[i] && !m_msgq[i]) s[i] = 1'b0;
      if (ch_event[i]) begin
        if (!glob_en || !ch_en[i]) s[i] = 1'b0;
        else if (ch_msg_en[i]) begin
          if (!rq) begin
            rq = 1'b1;
            m_addr = ch_msg_cfg[i*64+32 +: 32];
            m_data = ch_msg_cfg[i*64 +: 32];
          end
        end else if (ch_level[i]) s[i] = 1'b1;
        else begin s[i] = 1'b0; p[i] = 1'b1; end
      end
    end
    m_sts = s; m_pulse = p; m_req = rq; m_msgq = ch_msg_en;
    @(posedge clk);
    @(negedge clk);
    ch_event = '0; sts_wr = 0; sts_wdata = '0;
    compare(tag);
  endtask

  task automatic look(input string tag);
    #1 compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++)
      ch_msg_cfg[i*64 +: 64] = {32'hA000_0000 + 32'(i*16), 32'h0000_0C00 + 32'(i)};
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1;
    @(negedge clk);

    // near-exhaustive sweep: legacy x channel x (en, glob, level, msg)
    for (int leg = 0; leg < 2; leg++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int cfg = 0; cfg < 16; cfg++) begin
          string tg;
          legacy_en = leg[0];
          for (int k = 0; k < NCH; k++) ch_route[k*5 +: 5] = 5'((k*5 + cfg + 3) % 32);
          ch_en[ch] = cfg[0]; glob_en = cfg[1]; ch_level[ch] = cfg[2]; ch_msg_en[ch] = cfg[3];
          tick("R8");
          if (!cfg[0] || !cfg[1]) tg = "R5";
          else if (cfg[3]) tg = "R7";
          else if (cfg[2]) tg = (leg == 1 && ch < 2) ? "R2" : "R1";
          else tg = "R4";
          ch_event[ch] = 1'b1;
          tick(tg);
          tick(cfg[2] ? "R3" : "R4");
          sts_wr = 1; sts_wdata = '1;
          tick("R6");
          ch_msg_en[ch] = 1'b0; ch_en[ch] = 1'b0;
        end
      end
    end

    // OR of two channels on one line
    legacy_en = 0; glob_en = 1; ch_en = '1; ch_level = '1; ch_msg_en = '0;
    ch_route[0 +: 5] = 5'd5; ch_route[10 +: 5] = 5'd5;
    ch_event = 4'b0101; tick("R10");
    sts_wr = 1; sts_wdata = 4'b0001; tick("R10");
    sts_wr = 1; sts_wdata = 4'b0100; tick("R10");

    // acknowledge and new event on same channel in same cycle
    ch_event = 4'b1000; tick("R3");
    sts_wr = 1; sts_wdata = 4'b1000; ch_event = 4'b1000; tick("R6");
    sts_wr = 1; sts_wdata = 4'b1000; tick("R6");

    // two message events in one cycle: lower index wins
    ch_msg_en = 4'b0110; tick("R8");
    ch_event = 4'b0110; tick("R7");
    tick("R7");
    ch_msg_en = '0; tick("R7");

    // message enable rising releases a held level
    ch_event = 4'b0001; tick("R3");
    ch_msg_en = 4'b0001; tick("R8");
    ch_msg_en = '0; tick("R8");

    // clock passthrough on line 8
    rtc_irq = 1; look("R9");
    legacy_en = 1; look("R9");
    rtc_irq = 0; look("R9");
    rtc_irq = 1; look("R9");
    legacy_en = 0; look("R9");
    tick("R9");
    rtc_irq = 0; look("R9");

    // legacy pinning of channel 1 to line 8 with a level hold
    legacy_en = 1; ch_route[5 +: 5] = 5'd20;
    ch_event = 4'b0010; tick("R2");
    sts_wr = 1; sts_wdata = 4'b0010; tick("R2");

    // reset clears held state
    ch_event = 4'b0001; tick("R3");
    rst_n = 0; m_sts = '0; m_pulse = '0; m_req = 0; m_msgq = '0;
    @(posedge clk); @(negedge clk);
    compare("R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule